// File: doc/BRIEF.md
# Opcode-Decoded Accumulator ALU

This block is the accumulator arithmetic unit of an 8-bit processor core. It receives the raw opcode byte of the current instruction together with an operand byte. It decodes the opcode bit fields itself into one of eight two-operand operations, four rotates, a decimal adjust, an accumulator complement, or one of two carry-only operations. The accumulator and the five status flags live inside the block. When the enable is high, the new values are written on the rising clock edge.

The surrounding core fetches the operand byte from a register, from memory or from an immediate byte. The block only tells the core which of these sources the opcode asks for, and which register when it is a register form. Opcodes outside the supported set raise a combinational flag, and they leave the accumulator and flags untouched.

Top module: `opalu_top`

## Requirements
- R1: While `rstN` is low, `acc` is 0x00 and `flags` is 5'b00000. `flags` is packed as {sign, zero, aux, parity, carry}, with sign in bit 4 and carry in bit 0.
- R2: While `en` is low, a clock edge leaves `acc` and `flags` unchanged, whatever `opcode` and `operand` hold.
- R3: Opcodes 10 ooo sss and 11 ooo 110 pick their operation from ooo: 000 add, 001 add plus carry, 010 subtract, 011 subtract with borrow, 100 AND, 101 XOR, 110 OR, 111 compare. For the add forms, carry is the carry out of bit 7 and aux is the carry out of bit 3.
- R4: Subtract and subtract with borrow write acc minus operand (minus the old carry for the borrow form). Carry is set when the full byte borrows. Aux is set when the low nibble borrows, that is when acc[3:0] < operand[3:0] + borrow-in.
- R5: Compare sets the flags exactly as subtract does, and leaves `acc` unchanged.
- R6: AND, XOR and OR clear carry. AND sets aux to acc[3] | operand[3]. XOR and OR clear aux.
- R7: Opcodes 11 ooo 110 take the operand byte as an immediate and otherwise behave as the matching 10 ooo sss form.
- R8: Opcodes 00 0rr 111 rotate the accumulator. rr=00 rotates left with bit 7 copied into bit 0 and carry. rr=01 rotates right with bit 0 copied into bit 7 and carry. rr=10 rotates left through carry. rr=11 rotates right through carry. Rotates change only the carry flag.
- R9: Opcode 0x2F writes the bitwise inverse of `acc` and changes no flag. Opcode 0x37 sets carry. Opcode 0x3F inverts carry. Neither 0x37 nor 0x3F touches `acc` or the other flags.
- R10: Opcode 0x27 first adds 0x06 when acc[3:0] > 9 or aux is set; aux then becomes the carry out of bit 3 of that add. It next adds 0x60 when the intermediate high nibble is > 9, when carry is set, or when the first add overflowed; carry is set in that case and otherwise kept.
- R11: Whenever all flags are written, sign is bit 7 of the result, zero is set for a zero result, and parity is set when the result has an even number of ones. For compare, the result is the difference.
- R12: `srcKind` is 0 for no operand, 1 for a register (sss not 110), 2 for memory (sss = 110) and 3 for an immediate. `regSel` carries sss for register forms and is 0 otherwise. The register codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7.
- R13: `illegal` is high for any opcode not covered by R3 to R10, and such an opcode leaves `acc` and `flags` unchanged even with `en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Write enable for accumulator and flags |
| opcode | input | 8 | Raw instruction byte |
| operand | input | 8 | Operand byte supplied by the core |
| acc | output | 8 | Registered accumulator |
| flags | output | 5 | Registered flags {sign, zero, aux, parity, carry} |
| srcKind | output | 2 | Operand source requested by the opcode |
| regSel | output | 3 | Register code for register forms |
| illegal | output | 1 | Opcode outside the supported set |

## Verification
On every enabled cycle the assertions check the following: the hold with enable low, compare leaving the accumulator alone, the carry-only operations sparing the other four flags, the complement inverting the accumulator without touching any flag, logic operations clearing carry, and the sign, zero and parity flags agreeing with the stored result. Unsupported opcodes freezing the state is also checked each cycle. The numeric correctness of sums, borrows, aux carries, the rotate bit paths and the two-step decimal adjust can only be shown by the bench's chained scenarios. In those scenarios each result feeds the next operation, and the expected bytes and flags are worked out by hand from the requirements.

// File: rtl/opalu_pkg.sv
package opalu_pkg;
  localparam int DATA_W = 8;
  localparam int NIB_W = DATA_W / 2;
  localparam int FLAG_W = 5;
  localparam int FIELD_W = 3;

  // first eight values follow the ooo field; the next eight follow the 00xxx111 field
  typedef enum logic [4:0] {
    OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_AND, OP_XOR, OP_OR, OP_CMP,
    OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_DAA, OP_CMA, OP_STC, OP_CMC,
    OP_NONE
  } aluOp_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_REG, SRC_MEM, SRC_IMM} srcKind_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic aux;
    logic parity;
    logic carry;
  } flags_t;

  typedef struct packed {
    aluOp_e op;
    logic   wrAcc;
    logic   wrAll;
    logic   wrCarry;
  } ctrl_t;
endpackage

// File: rtl/opalu_ctrl.sv
module opalu_ctrl
  import opalu_pkg::*;
(
  input  logic [DATA_W-1:0]  opcode,
  output ctrl_t              ctrl,
  output srcKind_e           srcKind,
  output logic [FIELD_W-1:0] regSel,
  output logic               illegal
);
  localparam logic [FIELD_W-1:0] MEM_CODE = 3'b110;
  localparam logic [FIELD_W-1:0] ROT_TAIL = 3'b111;

  logic [1:0]         grp;
  logic [FIELD_W-1:0] mid;
  logic [FIELD_W-1:0] low;

  assign grp = opcode[DATA_W-1 -: 2];
  assign mid = opcode[2*FIELD_W-1 -: FIELD_W];
  assign low = opcode[FIELD_W-1:0];

  always_comb begin
    ctrl.op      = OP_NONE;
    ctrl.wrAcc   = 1'b0;
    ctrl.wrAll   = 1'b0;
    ctrl.wrCarry = 1'b0;
    srcKind      = SRC_NONE;
    regSel       = '0;
    illegal      = 1'b1;
    if (grp == 2'b10 || (grp == 2'b11 && low == MEM_CODE)) begin
      ctrl.op    = aluOp_e'({2'b00, mid});
      ctrl.wrAll = 1'b1;
      ctrl.wrAcc = (mid != 3'b111);
      illegal    = 1'b0;
      if (grp == 2'b11) begin
        srcKind = SRC_IMM;
      end else if (low == MEM_CODE) begin
        srcKind = SRC_MEM;
      end else begin
        srcKind = SRC_REG;
        regSel  = low;
      end
    end else if (grp == 2'b00 && low == ROT_TAIL) begin
      ctrl.op = aluOp_e'({2'b01, mid});
      illegal = 1'b0;
      unique case (ctrl.op)
        OP_DAA:         begin ctrl.wrAcc = 1'b1; ctrl.wrAll = 1'b1; end
        OP_CMA:         ctrl.wrAcc = 1'b1;
        OP_STC, OP_CMC: ctrl.wrCarry = 1'b1;
        default:        begin ctrl.wrAcc = 1'b1; ctrl.wrCarry = 1'b1; end
      endcase
    end
  end

  // R13 / R12: decode consistency
  always_comb begin
    assert_illegal_no_write_R13: assert (!illegal || !(ctrl.wrAcc || ctrl.wrAll || ctrl.wrCarry));
    assert_write_class_R9: assert ($onehot0({ctrl.wrAll, ctrl.wrCarry}));
    assert_regsel_R12: assert (srcKind == SRC_REG || regSel == '0);
  end
endmodule

// File: rtl/opalu_dp.sv
module opalu_dp
  import opalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] accQ,
  output flags_t            flagsQ
);
  localparam logic [DATA_W-1:0] LOW_FIX  = 8'h06;
  localparam logic [DATA_W-1:0] HIGH_FIX = 8'h60;
  localparam logic [NIB_W-1:0]  NINE     = 4'd9;

  logic              isSub;
  logic              carryIn;
  logic [DATA_W-1:0] bEff;
  logic              cEff;
  logic [DATA_W:0]   sum;
  logic [NIB_W:0]    nibSum;
  logic              lowAdj;
  logic              hiAdj;
  logic [DATA_W:0]   stepOne;
  logic [NIB_W:0]    stepNib;
  logic [DATA_W:0]   stepTwo;
  logic [DATA_W-1:0] res;
  logic              cyN;
  logic              acN;
  flags_t            flagsD;
  logic [DATA_W-1:0] accD;

  assign isSub   = (ctrl.op == OP_SUB) || (ctrl.op == OP_SBB) || (ctrl.op == OP_CMP);
  assign carryIn = ((ctrl.op == OP_ADC) || (ctrl.op == OP_SBB)) && flagsQ.carry;
  assign bEff    = isSub ? ~operand : operand;
  assign cEff    = isSub ? ~carryIn : carryIn;
  assign sum     = {1'b0, accQ} + {1'b0, bEff} + {{DATA_W{1'b0}}, cEff};
  assign nibSum  = {1'b0, accQ[NIB_W-1:0]} + {1'b0, bEff[NIB_W-1:0]} + {{NIB_W{1'b0}}, cEff};

  // decimal adjust, two steps
  assign lowAdj  = (accQ[NIB_W-1:0] > NINE) || flagsQ.aux;
  assign stepOne = {1'b0, accQ} + {1'b0, (lowAdj ? LOW_FIX : '0)};
  assign stepNib = {1'b0, accQ[NIB_W-1:0]} + {1'b0, (lowAdj ? LOW_FIX[NIB_W-1:0] : '0)};
  assign hiAdj   = (stepOne[DATA_W-1 -: NIB_W] > NINE) || flagsQ.carry || stepOne[DATA_W];
  assign stepTwo = {1'b0, stepOne[DATA_W-1:0]} + {1'b0, (hiAdj ? HIGH_FIX : '0)};

  always_comb begin
    res = accQ;
    cyN = flagsQ.carry;
    acN = flagsQ.aux;
    unique case (ctrl.op)
      OP_ADD, OP_ADC: begin res = sum[DATA_W-1:0]; cyN = sum[DATA_W]; acN = nibSum[NIB_W]; end
      OP_SUB, OP_SBB, OP_CMP: begin
        res = sum[DATA_W-1:0]; cyN = ~sum[DATA_W]; acN = ~nibSum[NIB_W];
      end
      OP_AND: begin res = accQ & operand; cyN = 1'b0; acN = accQ[3] | operand[3]; end
      OP_XOR: begin res = accQ ^ operand; cyN = 1'b0; acN = 1'b0; end
      OP_OR:  begin res = accQ | operand; cyN = 1'b0; acN = 1'b0; end
      OP_RLC: begin res = {accQ[DATA_W-2:0], accQ[DATA_W-1]}; cyN = accQ[DATA_W-1]; end
      OP_RRC: begin res = {accQ[0], accQ[DATA_W-1:1]}; cyN = accQ[0]; end
      OP_RAL: begin res = {accQ[DATA_W-2:0], flagsQ.carry}; cyN = accQ[DATA_W-1]; end
      OP_RAR: begin res = {flagsQ.carry, accQ[DATA_W-1:1]}; cyN = accQ[0]; end
      OP_DAA: begin res = stepTwo[DATA_W-1:0]; cyN = flagsQ.carry | hiAdj; acN = stepNib[NIB_W]; end
      OP_CMA: res = ~accQ;
      OP_STC: cyN = 1'b1;
      OP_CMC: cyN = ~flagsQ.carry;
      default: ;
    endcase
  end

  always_comb begin
    flagsD = flagsQ;
    accD   = ctrl.wrAcc ? res : accQ;
    if (ctrl.wrAll) begin
      flagsD.sign   = res[DATA_W-1];
      flagsD.zero   = (res == '0);
      flagsD.aux    = acN;
      flagsD.parity = ~^res;
      flagsD.carry  = cyN;
    end else if (ctrl.wrCarry) begin
      flagsD.carry = cyN;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      flagsQ <= '0;
    end else if (en) begin
      accQ   <= accD;
      flagsQ <= flagsD;
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(accQ) && $stable(flagsQ)));
  assert_cmp_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.op == OP_CMP) |=> $stable(accQ));
  assert_logic_clears_carry_R6: assert property (@(posedge clk) disable iff (!rstN)
    (en && (ctrl.op == OP_AND || ctrl.op == OP_XOR || ctrl.op == OP_OR)) |=> !flagsQ.carry);
  assert_carry_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.wrCarry) |=> $stable({flagsQ.sign, flagsQ.zero, flagsQ.aux, flagsQ.parity}));
  assert_complement_R9: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.op == OP_CMA) |=> (accQ == ~$past(accQ) && $stable(flagsQ)));
  assert_set_carry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.op == OP_STC) |=> flagsQ.carry);
  assert_result_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.wrAll && ctrl.wrAcc) |=>
      (flagsQ.zero == (accQ == '0) && flagsQ.sign == accQ[DATA_W-1] && flagsQ.parity == ~^accQ));
  assert_unsupported_frozen_R13: assert property (@(posedge clk) disable iff (!rstN)
    (en && ctrl.op == OP_NONE) |=> ($stable(accQ) && $stable(flagsQ)));
endmodule

// File: rtl/opalu_top.sv
module opalu_top
  import opalu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [DATA_W-1:0] opcode,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] acc,
  output logic [FLAG_W-1:0] flags,
  output logic [1:0]        srcKind,
  output logic [FIELD_W-1:0] regSel,
  output logic              illegal
);
  ctrl_t    ctrl;
  srcKind_e kindE;
  flags_t   flagsQ;

  opalu_ctrl u_ctrl (
    .opcode  (opcode),
    .ctrl    (ctrl),
    .srcKind (kindE),
    .regSel  (regSel),
    .illegal (illegal)
  );

  opalu_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .ctrl    (ctrl),
    .operand (operand),
    .accQ    (acc),
    .flagsQ  (flagsQ)
  );

  assign flags   = flagsQ;
  assign srcKind = kindE;
endmodule

// File: tb/opalu_top_bench.sv
module opalu_top_bench;
  // vector: opcode, operand, expAcc, expFlags{S,Z,AC,P,CY}, expKind, expIllegal, reqId
  localparam int NV = 27;
  localparam logic [35:0] VEC [NV] = '{
    {8'hF6, 8'h35, 8'h35, 5'b00010, 2'd3, 1'b0, 4'd7},  // R7 ORI
    {8'hC6, 8'hCB, 8'h00, 5'b01111, 2'd3, 1'b0, 4'd3},  // R3 ADI carry + aux
    {8'hCE, 8'h10, 8'h11, 5'b00010, 2'd3, 1'b0, 4'd3},  // R3 ACI uses carry
    {8'hD6, 8'h12, 8'hFF, 5'b10111, 2'd3, 1'b0, 4'd4},  // R4 SUI borrow
    {8'hDE, 8'h0F, 8'hEF, 5'b10100, 2'd3, 1'b0, 4'd4},  // R4 SBI with borrow
    {8'hFE, 8'hEF, 8'hEF, 5'b01010, 2'd3, 1'b0, 4'd5},  // R5 CPI equal
    {8'hA0, 8'h38, 8'h28, 5'b00110, 2'd1, 1'b0, 4'd6},  // R6 AND reg B, aux rule
    {8'hAE, 8'hFF, 8'hD7, 5'b10010, 2'd2, 1'b0, 4'd6},  // R6 XOR memory
    {8'h07, 8'h00, 8'hAF, 5'b10011, 2'd0, 1'b0, 4'd8},  // R8 rotate left
    {8'h1F, 8'h00, 8'hD7, 5'b10011, 2'd0, 1'b0, 4'd8},  // R8 right through carry
    {8'h0F, 8'h00, 8'hEB, 5'b10011, 2'd0, 1'b0, 4'd8},  // R8 rotate right
    {8'h3F, 8'h00, 8'hEB, 5'b10010, 2'd0, 1'b0, 4'd9},  // R9 invert carry
    {8'h17, 8'h00, 8'hD6, 5'b10011, 2'd0, 1'b0, 4'd8},  // R8 left through carry
    {8'h2F, 8'h00, 8'h29, 5'b10011, 2'd0, 1'b0, 4'd9},  // R9 complement acc
    {8'hB7, 8'h00, 8'h29, 5'b00000, 2'd1, 1'b0, 4'd11}, // R11 OR reg A, odd parity
    {8'h37, 8'h00, 8'h29, 5'b00001, 2'd0, 1'b0, 4'd9},  // R9 set carry
    {8'hE6, 8'h00, 8'h00, 5'b01110, 2'd3, 1'b0, 4'd6},  // R6 ANI zero result
    {8'hC6, 8'h9B, 8'h9B, 5'b10000, 2'd3, 1'b0, 4'd3},  // R3 ADI
    {8'h27, 8'h00, 8'h01, 5'b00101, 2'd0, 1'b0, 4'd10}, // R10 both adjusts
    {8'h8B, 8'h08, 8'h0A, 5'b00010, 2'd1, 1'b0, 4'd3},  // R3 ADC reg E
    {8'h27, 8'h00, 8'h10, 5'b00100, 2'd0, 1'b0, 4'd10}, // R10 low adjust only
    {8'h76, 8'h55, 8'h10, 5'b00100, 2'd0, 1'b1, 4'd13}, // R13 unsupported
    {8'h99, 8'h10, 8'h00, 5'b01010, 2'd1, 1'b0, 4'd4},  // R4 SBB reg C, no borrow
    {8'h92, 8'h01, 8'hFF, 5'b10111, 2'd1, 1'b0, 4'd4},  // R4 SUB reg D wraps
    {8'h80, 8'h01, 8'h00, 5'b01111, 2'd1, 1'b0, 4'd3},  // R3 ADD reg B wraps
    {8'hBD, 8'h01, 8'h00, 5'b10111, 2'd1, 1'b0, 4'd5},  // R5 CMP reg L borrow
    {8'hC3, 8'h00, 8'h00, 5'b10111, 2'd0, 1'b1, 4'd13}  // R13 unsupported
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [7:0] operand = 8'h00;
  logic [7:0] acc;
  logic [4:0] flags;
  logic [1:0] srcKind;
  logic [2:0] regSel;
  logic       illegal;
  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  opalu_top u_opalu_top (
    .clk(clk), .rstN(rstN), .en(en), .opcode(opcode), .operand(operand),
    .acc(acc), .flags(flags), .srcKind(srcKind), .regSel(regSel), .illegal(illegal)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "acc at reset", acc, 8'h00);
    check("R1", "flags at reset", {3'b0, flags}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      logic [2:0] expSel;
      tag = $sformatf("R%0d", VEC[i][3:0]);
      opcode  = VEC[i][35:28];
      operand = VEC[i][27:20];
      en = 1'b1;
      #1;
      expSel = (VEC[i][6:5] == 2'd1) ? VEC[i][30:28] : 3'd0;
      check("R12", "srcKind", {6'b0, srcKind}, {6'b0, VEC[i][6:5]});
      check("R12", "regSel", {5'b0, regSel}, {5'b0, expSel});
      check("R13", "illegal", {7'b0, illegal}, {7'b0, VEC[i][4]});
      @(negedge clk);
      check(tag, "acc", acc, VEC[i][19:12]);
      check(tag, "flags", {3'b0, flags}, {3'b0, VEC[i][11:7]});
    end

    // R2: enable low holds state against an add
    en = 1'b0;
    opcode = 8'hC6; operand = 8'h44;
    repeat (2) @(negedge clk);
    check("R2", "acc held", acc, 8'h00);
    check("R2", "flags held", {3'b0, flags}, 8'h17);

    // R7: immediate SUB matches register SUB; prepare acc=0x50
    en = 1'b1;
    opcode = 8'hF6; operand = 8'h50; @(negedge clk);
    opcode = 8'hD6; operand = 8'h51; @(negedge clk);
    check("R7", "imm sub acc", acc, 8'hFF);
    check("R7", "imm sub flags", {3'b0, flags}, 8'h17);

    // R10: decimal adjust with carry already set, acc=0x00 after R10 high adjust
    opcode = 8'hE6; operand = 8'h00; @(negedge clk); // acc 0, flags 01110 (bit3 of FF set)
    opcode = 8'h37; @(negedge clk);                  // carry set, flags 01111
    opcode = 8'h27; @(negedge clk);                  // +06 (aux) then +60 (carry)
    check("R10", "daa acc", acc, 8'h66);
    check("R10", "daa flags", {3'b0, flags}, 8'h03);

    // R1: reset in mid-run clears state
    rstN = 1'b0; #1;
    check("R1", "acc after reset", acc, 8'h00);
    check("R1", "flags after reset", {3'b0, flags}, 8'h00);
    en = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule